// File: doc/BRIEF.md
# Sound Sample DMA Buffer with Memory Slot Arbiter

This block streams 8-bit audio samples from memory into a small byte buffer and hands them to a converter that runs on its own sample clock. Memory is divided into fixed slots of `PH_LEN` clocks. At each slot boundary an arbiter gives the next slot to the video fetch, to the sound fetch or to refresh, in that order of precedence. The sound fetch asks for a slot whenever it is enabled, has not reached its end address, and the buffer has room for a whole 16-bit word.

The fetch address walks from a start address toward an end address, two bytes per fetched word. When the end is reached, fetching either stops or starts again at the start address. The address seen by software therefore runs ahead of playback by up to the buffer depth. Clearing the enable flushes the buffer, clears the underrun flag and makes the visible address equal to the start address in the same cycle.

The sample strobe is asynchronous. It is synchronised inside the block, and each rising edge consumes one byte in mono or two bytes in stereo. If too few bytes are buffered when the strobe arrives, the outputs hold their last value and a sticky underrun flag is raised.

Top module: `snd_dma_fifo`

## Requirements
- R1: Memory slots last `PH_LEN` clocks, counted from reset. `phase_sel` changes only at a slot boundary and holds for the whole slot.
- R2: Encoding of `phase_sel`: 2'b01 is video, 2'b10 is sound, 2'b00 is refresh. If `video_req` is high at a boundary, the next slot is video. Otherwise it is sound if the sound request is active. Otherwise it is refresh.
- R3: The sound request is active when the block is enabled, has not stopped at the end address, and at least 2 bytes of the `DEPTH`-byte buffer are free. The buffer count includes the word and the strobe handled at the same boundary. The buffer never holds more than `DEPTH` bytes, so without strobes fetching stalls at `start_addr + DEPTH`.
- R4: A fetched word enters the buffer as two bytes, high byte `mem_rdata[15:8]` first and low byte second. It is captured in the last clock of the sound slot.
- R5: Mono: a strobe pops one byte onto both `left_out` and `right_out`. Stereo: a strobe pops two bytes, the first to `left_out` and the second to `right_out`.
- R6: The strobe passes through two synchroniser flops and an edge detector. Its effect shows at the outputs after the third rising clock edge following the strobe's rise, and there is one pop per rising edge.
- R7: A strobe that finds fewer bytes than it needs leaves the outputs unchanged and sets `underrun`. `underrun` stays set until the block is disabled.
- R8: During a sound slot `mem_rd` is high and `mem_addr` equals `cur_addr`. The address advances by 2 when the word is captured.
- R9: When the advanced address equals `end_addr`, one of two things happens. With `loop_en` high it reloads `start_addr`. Otherwise it stays at `end_addr` and no further sound slot is requested.
- R10: While `dma_en` is low, `cur_addr` equals `start_addr` combinationally. The buffer is emptied, `underrun` is cleared, and strobes are ignored.
- R11: After reset `phase_sel` is refresh, `mem_rd` is 0, both sample outputs are 0 and `underrun` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_en | input | 1 | Enables fetching and playback |
| stereo | input | 1 | 1: two bytes per strobe; 0: one byte |
| loop_en | input | 1 | Restart at start address when the end is reached |
| video_req | input | 1 | Video fetch wants the next slot |
| start_addr | input | AW | Byte address of the first word |
| end_addr | input | AW | Byte address one past the last word |
| cur_addr | output | AW | Current fetch address |
| phase_sel | output | 2 | Owner of the current memory slot |
| mem_rd | output | 1 | Sound read in this slot |
| mem_addr | output | AW | Byte address of the sound read |
| mem_rdata | input | 16 | Read word, valid in the last clock of the slot |
| sample_stb | input | 1 | Asynchronous sample strobe |
| left_out | output | 8 | Left (or mono) sample |
| right_out | output | 8 | Right (or mono) sample |
| underrun | output | 1 | Sticky underrun flag |

## Verification
The bench builds the block with a 16-bit address, an 8-byte buffer and 4-clock slots. These values make the buffer small enough that fetching stalls on a full buffer within a few slots. They also keep address windows short enough that the end-address stop and the loop reload happen many times within a run. Pseudo-random video demand combined with fast stereo strobes starves the sound fetch and reaches underrun. A slow mono stream reaches the end address without loop and then drains the buffer until it runs empty.

// File: rtl/snd_dma_fifo.sv
module snd_dma_fifo #(
  parameter int AW     = 16,
  parameter int DEPTH  = 8,
  parameter int PH_LEN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dma_en,
  input  logic          stereo,
  input  logic          loop_en,
  input  logic          video_req,
  input  logic [AW-1:0] start_addr,
  input  logic [AW-1:0] end_addr,
  output logic [AW-1:0] cur_addr,
  output logic [1:0]    phase_sel,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [15:0]   mem_rdata,
  input  logic          sample_stb,
  output logic [7:0]    left_out,
  output logic [7:0]    right_out,
  output logic          underrun
);
  localparam int PW = $clog2(PH_LEN);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [1:0] G_REF = 2'b00, G_VID = 2'b01, G_SND = 2'b10;

  logic [PW-1:0] ph;
  logic [1:0]    grant, grant_nx;
  logic [AW-1:0] addr_q, addr_nx, addr_inc;
  logic          done_q, done_nx;
  logic [7:0]    fifo [DEPTH];
  logic [IW-1:0] rp, wp;
  logic [CW-1:0] cnt, cnt_nx;
  logic          s1, s2, s3;
  logic [7:0]    l_q, r_q;
  logic          und_q;

  wire       last    = (ph == PW'(PH_LEN - 1));
  wire       push    = dma_en && last && (grant == G_SND);
  wire       pop_req = s2 && !s3 && dma_en;
  wire [1:0] need    = stereo ? 2'd2 : 2'd1;
  wire       pop_ok  = pop_req && (cnt >= CW'(need));
  wire       snd_req = dma_en && !done_nx && ((CW'(DEPTH) - cnt_nx) >= CW'(2));

  assign addr_inc  = addr_q + AW'(2);
  assign cnt_nx    = cnt + (push ? CW'(2) : CW'(0)) - (pop_ok ? CW'(need) : CW'(0));
  assign grant_nx  = video_req ? G_VID : (snd_req ? G_SND : G_REF);
  assign cur_addr  = dma_en ? addr_q : start_addr;
  assign phase_sel = grant;
  assign mem_rd    = (grant == G_SND);
  assign mem_addr  = addr_q;
  assign left_out  = l_q;
  assign right_out = r_q;
  assign underrun  = und_q;

  always_comb begin
    addr_nx = addr_q;
    done_nx = done_q;
    if (!dma_en) begin
      addr_nx = start_addr;
      done_nx = 1'b0;
    end else if (push) begin
      if (addr_inc == end_addr) begin
        addr_nx = loop_en ? start_addr : addr_inc;
        done_nx = !loop_en;
      end else begin
        addr_nx = addr_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= '0;
      grant  <= G_REF;
      addr_q <= '0;
      done_q <= 1'b0;
      {s1, s2, s3} <= 3'b000;
    end else begin
      ph     <= ph + PW'(1);
      addr_q <= addr_nx;
      done_q <= done_nx;
      s1 <= sample_stb;
      s2 <= s1;
      s3 <= s2;
      if (last) grant <= grant_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp <= '0; wp <= '0; cnt <= '0;
      l_q <= '0; r_q <= '0; und_q <= 1'b0;
    end else if (!dma_en) begin
      rp <= '0; wp <= '0; cnt <= '0;
      und_q <= 1'b0;
    end else begin
      cnt <= cnt_nx;
      if (push) wp <= wp + IW'(2);
      if (pop_ok) begin
        rp  <= rp + IW'(need);
        l_q <= fifo[rp];
        r_q <= stereo ? fifo[rp + IW'(1)] : fifo[rp];
      end else if (pop_req) begin
        und_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      fifo[wp]          <= mem_rdata[15:8];
      fifo[wp + IW'(1)] <= mem_rdata[7:0];
    end
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  // R1
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !last |=> $stable(phase_sel));
  // R2
  video_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last && video_req) |=> (phase_sel == G_VID));
  // R10
  disable_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |=> (cnt == '0 && !underrun));
  // R7
  underrun_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !pop_ok) |=> (underrun && $stable(left_out) && $stable(right_out)));
  // R9
  stop_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_en && done_q) |-> !push);
endmodule

// File: tb/snd_dma_fifo_test.sv
`timescale 1ns/1ps
module snd_dma_fifo_test;
  localparam int AW = 16, DEPTH = 8, PH_LEN = 4;

  logic clk = 0, rst_n = 0;
  logic dma_en = 0, stereo = 0, loop_en = 0, video_req = 0, sample_stb = 0;
  logic [AW-1:0] start_addr = '0, end_addr = '0;
  logic [AW-1:0] cur_addr, mem_addr;
  logic [1:0] phase_sel;
  logic mem_rd, underrun;
  logic [15:0] mem_rdata;
  logic [7:0] left_out, right_out;

  always #2.5 clk = ~clk;

  function automatic logic [15:0] mem_word(input logic [AW-1:0] a);
    return {a[8:1] ^ 8'hA5, a[7:0] + 8'h3C};
  endfunction
  assign mem_rdata = mem_word(mem_addr);

  snd_dma_fifo #(.AW(AW), .DEPTH(DEPTH), .PH_LEN(PH_LEN)) uut (
    .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .stereo(stereo), .loop_en(loop_en),
    .video_req(video_req), .start_addr(start_addr), .end_addr(end_addr),
    .cur_addr(cur_addr), .phase_sel(phase_sel), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .sample_stb(sample_stb), .left_out(left_out),
    .right_out(right_out), .underrun(underrun));

  int total = 0, fails = 0;
  bit cmp_on = 0, finished = 0;

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // reference model
  int m_ph = 0, m_grant = 0;
  logic [AW-1:0] m_addr = '0;
  bit m_done = 0, m_und = 0, ms1 = 0, ms2 = 0, ms3 = 0;
  logic [7:0] q[$];
  logic [7:0] m_l = 0, m_r = 0;

  always @(posedge clk) begin : model
    bit ed;
    int n;
    logic [15:0] w;
    if (!rst_n) begin
      m_ph = 0; m_grant = 0; m_addr = '0; m_done = 0; m_und = 0;
      ms1 = 0; ms2 = 0; ms3 = 0; q.delete(); m_l = 0; m_r = 0;
    end else begin
      ed = ms2 && !ms3;
      ms3 = ms2; ms2 = ms1; ms1 = sample_stb;
      if (!dma_en) begin
        q.delete(); m_addr = start_addr; m_done = 0; m_und = 0;
      end else begin
        n = stereo ? 2 : 1;
        if (ed) begin
          if (q.size() >= n) begin
            m_l = q.pop_front();
            m_r = stereo ? q.pop_front() : m_l;
          end else m_und = 1;
        end
        if (m_ph == PH_LEN - 1 && m_grant == 2) begin
          w = mem_word(m_addr);
          q.push_back(w[15:8]);
          q.push_back(w[7:0]);
          m_addr = m_addr + AW'(2);
          if (m_addr == end_addr) begin
            if (loop_en) m_addr = start_addr; else m_done = 1;
          end
        end
      end
      if (m_ph == PH_LEN - 1)
        m_grant = video_req ? 1 : ((dma_en && !m_done && (DEPTH - q.size()) >= 2) ? 2 : 0);
      m_ph = (m_ph + 1) % PH_LEN;
    end
  end

  always @(posedge clk) begin
    #1;
    if (rst_n && cmp_on) begin
      chk("R1/R2 phase_sel", phase_sel, m_grant);
      chk("R8 mem_rd", mem_rd, m_grant == 2);
      if (mem_rd) chk("R8 mem_addr", mem_addr, m_addr);
      chk(dma_en ? "R9 cur_addr" : "R10 cur_addr", cur_addr, dma_en ? m_addr : start_addr);
      chk("R4/R5/R6 left_out", left_out, m_l);
      chk("R5/R6 right_out", right_out, m_r);
      chk("R7 underrun", underrun, m_und);
    end
  end

  // stimulus generators
  int stb_per = 0, stb_cnt = 0;
  bit vid_mode = 0;
  logic [7:0] lf = 8'h01;
  always @(negedge clk) begin
    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    video_req = vid_mode && (lf[2:0] != 3'b000);
    if (stb_per > 0) begin
      sample_stb = (stb_cnt % stb_per) < 3;
      stb_cnt++;
    end
  end

  task automatic stb_off();
    @(negedge clk); stb_per = 0;
    @(negedge clk); sample_stb = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    start_addr = 16'h0100; end_addr = 16'h0140;
    repeat (3) @(negedge clk);
    @(posedge clk); #1;
    chk("R11 phase_sel", phase_sel, 0);
    chk("R11 mem_rd", mem_rd, 0);
    chk("R11 left_out", left_out, 0);
    chk("R11 right_out", right_out, 0);
    chk("R11 underrun", underrun, 0);
    @(negedge clk); rst_n = 1; cmp_on = 1;

    // mono, no loop, no video
    @(negedge clk); dma_en = 1; stereo = 0; loop_en = 0;
    repeat (30) @(negedge clk);
    chk("R3 stall at full", cur_addr, 16'h0108);
    sample_stb = 1; repeat (3) @(negedge clk); sample_stb = 0;
    chk("R4 first byte left", left_out, mem_word(16'h0100) >> 8);
    chk("R5 mono right", right_out, mem_word(16'h0100) >> 8);
    stb_cnt = 0; stb_per = 40;
    repeat (3200) @(negedge clk);
    chk("R9 stopped at end", cur_addr, 16'h0140);
    chk("R7 drained", underrun, 1);
    stb_off();
    dma_en = 0; #1;
    chk("R10 snap to start", cur_addr, 16'h0100);
    repeat (5) @(negedge clk);
    chk("R10 underrun cleared", underrun, 0);

    // stereo, loop, heavy video, fast strobes
    start_addr = 16'h0400; end_addr = 16'h0410; stereo = 1; loop_en = 1; vid_mode = 1;
    @(negedge clk); dma_en = 1;
    stb_cnt = 0; stb_per = 8;
    repeat (4000) @(negedge clk);
    stb_off();
    dma_en = 0; vid_mode = 0;
    repeat (4) @(negedge clk);

    // stereo, loop, no video, fed fast enough
    dma_en = 1;
    repeat (24) @(negedge clk);
    stb_cnt = 0; stb_per = 12;
    repeat (3000) @(negedge clk);
    chk("R7 no underrun when fed", underrun, 0);
    chk("R9 loop window", (cur_addr >= 16'h0400) && (cur_addr < 16'h0410), 1);
    stb_off();

    // mono, loop, video, disable mid-run while strobing
    dma_en = 0; @(negedge clk);
    stereo = 0; start_addr = 16'h0080; end_addr = 16'h00A0; vid_mode = 1;
    @(negedge clk); dma_en = 1;
    stb_cnt = 0; stb_per = 7;
    repeat (1500) @(negedge clk);
    dma_en = 0; #1;
    chk("R10 snap mid-run", cur_addr, 16'h0080);
    repeat (200) @(negedge clk);
    chk("R10 strobes ignored", underrun, 0);
    dma_en = 1;
    repeat (1500) @(negedge clk);
    stb_off();
    repeat (10) @(negedge clk);

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule